// File: doc/BRIEF.md
# Host Command Mailbox Responder

This block is the device end of a register mailbox. A host posts control commands and collects multi-word results through three regions of a 32-bit register port: a command word, a handshake/status word and a result window. On the device side it issues a one-cycle command strobe with the command code and queue index to a backend. It then takes result words from a valid/ready stream and a completion strobe with an error code.

A result larger than the window is handed over in pieces. The block fills the window from index 0 and publishes the piece size. It raises a ready flag and waits until the host writes the status word back with that flag clear. The busy flag drops on the last piece. The command word returns to zero only when the host has taken that last piece, so a zero command word means the mailbox is free. A commandless acknowledgement uses the same path with a requested size of zero. A compatibility mode, picked at reset, uses only the command word: it is cleared when the backend reports completion.

Top module: `cmd_mailbox`

## Requirements
- R1: Register map by word address: 0 is the command word (code in bits 15:0, queue index in bits 31:16), 1 is the status word (piece size 15:0, busy flag bit 16, ready flag bit 17, error code 27:18), and addresses WIN_DEPTH..2*WIN_DEPTH-1 read result window entries 0..WIN_DEPTH-1. After reset, the command word, the status word, `cmd_valid` and `be_ready` are all zero.
- R2: In piece mode, a nonzero write to the command word while the mailbox is free is stored. On the next cycle it raises `cmd_valid` with `cmd_opcode`/`cmd_qidx` taken from bits 15:0 and 31:16, and the status word shows busy set and ready clear.
- R3: Accepted result words go to the window from index 0 in arrival order. A piece closes when it holds WIN_DEPTH words or when the running total reaches the requested size, written earlier to status bits 15:0 while free. The block then sets ready and shows the piece size, and `be_ready` is low while ready is set.
- R4: While ready is set, a status write with bit 17 clear takes the piece and starts the next one. A status write with bit 17 set is ignored.
- R5: Busy drops on the last piece. The command word keeps its value until the host takes that last piece, and it is zero on the cycle after.
- R6: With a requested size of zero, the block waits for `be_done`. It then shows ready set, busy clear, size zero and `be_err` in bits 27:18. Taking that piece clears the command word.
- R7: `be_done` with a nonzero code ends the transfer as a last piece carrying the code. While the error field is nonzero, a new nonzero command write is accepted and clears the field.
- R8: A nonzero command write while a command is active and the error field is zero leaves the command word unchanged and raises no `cmd_valid`.
- R9: Writing zero to the command word at any time returns to free: the command word is zero, busy and ready are clear, and `be_ready` is low.
- R10: `mode_legacy` is sampled while reset is held. In compatibility mode, a nonzero command write raises `cmd_valid`, and `be_done` clears the command word. The status word reads zero and ignores writes, and `be_ready` stays low.
- R11: `cmd_valid` is high for exactly one cycle per accepted command.
- R12: A `be_done` that arrives while a non-final piece waits for the host is held. After the host takes that piece, a zero-word last piece follows with busy clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_legacy | input | 1 | Compatibility mode select, sampled during reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | ADDR_W | Host word address (read and write) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |
| cmd_valid | output | 1 | One-cycle command strobe to backend |
| cmd_opcode | output | 16 | Command code |
| cmd_qidx | output | 16 | Queue index |
| be_valid | input | 1 | Backend result word valid |
| be_data | input | 32 | Backend result word |
| be_ready | output | 1 | Block accepts a result word |
| be_done | input | 1 | Backend completion strobe |
| be_err | input | 10 | Completion error code, 0 for success |

## Verification
Two functions can fall in the same cycle: the backend's completion strobe and the host's piece handshake. A completion can land while a piece waits for the host, or on the same cycle a word closes a full window. The bench provokes the first by stopping the word stream at a full window and pulsing `be_done` before writing the acknowledge. The check is the zero-word last piece that must follow, and the command word must stay set until that piece is taken. The error path is run the same way, with a restart accepted only because the error field is nonzero.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int REG_W      = 32;
   localparam int SIZE_W     = 16;
   localparam int ERR_W      = 10;
   localparam int BUSY_BIT   = 16;
   localparam int RDY_BIT    = 17;
   localparam int ERR_LSB    = 18;
   localparam int ADDR_CMD   = 0;
   localparam int ADDR_STAT  = 1;

   typedef enum logic [1:0] {
      ST_FREE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_SHOW  = 2'd2,
      ST_LWAIT = 2'd3
   } mbx_state_e;
endpackage

// File: rtl/mbx_window.sv
module mbx_window #(
   parameter int DEPTH = 16,
   parameter int W     = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [W-1:0]     rdata
);
   logic [W-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] entry_q;
      always_ff @(posedge clk) begin
         if (we && (widx == IDX_W'(g))) entry_q <= wdata;
      end
      assign slot[g] = entry_q;
   end

   assign rdata = slot[ridx];
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
   import mbx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              legacy,
   input  logic              cmd_wr,
   input  logic              stat_wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              be_valid,
   input  logic              be_done,
   input  logic [ERR_W-1:0]  be_err,
   output logic              be_ready,
   output logic              win_we,
   output logic [IDX_W-1:0]  win_idx,
   output logic              cmd_valid,
   output logic [REG_W-1:0]  cmd_word,
   output logic [REG_W-1:0]  stat_word
);
   mbx_state_e        st_q;
   logic [REG_W-1:0]  cmd_q;
   logic [SIZE_W-1:0] req_q, sent_q;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic              rdy_q, busy_q, last_q, held_done_q, pulse_q;
   logic [ERR_W-1:0]  err_q;
   logic [SIZE_W:0]   tot_q, tot_n;
   logic              take, reached, done_any, close_pc, last_n;
   logic              start_ok, abort, ack;
   logic [SIZE_W-1:0] size_f;

   assign abort    = cmd_wr && (wdata == '0);
   assign start_ok = cmd_wr && (wdata != '0) &&
                     ((st_q == ST_FREE) || (!legacy && (err_q != '0)));
   assign ack      = stat_wr && !wdata[RDY_BIT] && (st_q == ST_SHOW);

   assign tot_q    = {1'b0, sent_q} + (SIZE_W+1)'(cnt_q);
   assign be_ready = (st_q == ST_FILL) && (cnt_q < CNT_W'(DEPTH)) &&
                     (tot_q < {1'b0, req_q});
   assign take     = be_ready && be_valid;
   assign cnt_n    = cnt_q + CNT_W'(take);
   assign tot_n    = {1'b0, sent_q} + (SIZE_W+1)'(cnt_n);
   assign reached  = (req_q != '0) && (tot_n == {1'b0, req_q});
   assign done_any = be_done || held_done_q;
   assign last_n   = reached || done_any;
   assign close_pc = (st_q == ST_FILL) &&
                     ((cnt_n == CNT_W'(DEPTH)) || reached || done_any);

   assign win_we   = take;
   assign win_idx  = cnt_q[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_FREE;
         cmd_q       <= '0;
         req_q       <= '0;
         sent_q      <= '0;
         cnt_q       <= '0;
         rdy_q       <= 1'b0;
         busy_q      <= 1'b0;
         last_q      <= 1'b0;
         held_done_q <= 1'b0;
         err_q       <= '0;
         pulse_q     <= 1'b0;
      end else begin
         pulse_q <= start_ok;
         if (abort) begin
            st_q        <= ST_FREE;
            cmd_q       <= '0;
            rdy_q       <= 1'b0;
            busy_q      <= 1'b0;
            err_q       <= '0;
            cnt_q       <= '0;
            held_done_q <= 1'b0;
         end else if (start_ok) begin
            cmd_q       <= wdata;
            cnt_q       <= '0;
            sent_q      <= '0;
            rdy_q       <= 1'b0;
            err_q       <= '0;
            held_done_q <= 1'b0;
            last_q      <= 1'b0;
            if (legacy) begin
               st_q <= ST_LWAIT;
            end else begin
               st_q   <= ST_FILL;
               busy_q <= 1'b1;
            end
         end else begin
            unique case (st_q)
               ST_FREE: begin
                  if (stat_wr && !legacy) req_q <= wdata[SIZE_W-1:0];
               end
               ST_FILL: begin
                  cnt_q <= cnt_n;
                  if (be_done) begin
                     err_q       <= be_err;
                     held_done_q <= 1'b1;
                  end
                  if (close_pc) begin
                     st_q   <= ST_SHOW;
                     rdy_q  <= 1'b1;
                     last_q <= last_n;
                     busy_q <= !last_n;
                  end
               end
               ST_SHOW: begin
                  if (be_done) begin
                     err_q       <= be_err;
                     held_done_q <= 1'b1;
                  end
                  if (ack) begin
                     rdy_q <= 1'b0;
                     cnt_q <= '0;
                     if (last_q) begin
                        st_q  <= ST_FREE;
                        cmd_q <= '0;
                     end else begin
                        sent_q <= sent_q + SIZE_W'(cnt_q);
                        st_q   <= ST_FILL;
                     end
                  end
               end
               ST_LWAIT: begin
                  if (be_done) begin
                     st_q  <= ST_FREE;
                     cmd_q <= '0;
                  end
               end
               default: st_q <= ST_FREE;
            endcase
         end
      end
   end

   assign size_f    = (st_q == ST_FREE) ? req_q : SIZE_W'(cnt_q);
   assign cmd_valid = pulse_q;
   assign cmd_word  = cmd_q;
   assign stat_word = legacy ? '0 :
                      {{(REG_W-ERR_LSB-ERR_W){1'b0}}, err_q, rdy_q, busy_q, size_f};
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import mbx_pkg::*;
#(
   parameter int WIN_DEPTH = 16,
   parameter bit LEGACY_EN = 1'b1,
   localparam int IDX_W  = $clog2(WIN_DEPTH),
   localparam int ADDR_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_legacy,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              cmd_valid,
   output logic [15:0]       cmd_opcode,
   output logic [15:0]       cmd_qidx,
   input  logic              be_valid,
   input  logic [31:0]       be_data,
   output logic              be_ready,
   input  logic              be_done,
   input  logic [9:0]        be_err
);
   if (WIN_DEPTH < 2 || (1 << IDX_W) != WIN_DEPTH || WIN_DEPTH > 4096) begin : g_bad_depth
      $error("cmd_mailbox: WIN_DEPTH must be a power of two in 2..4096");
   end

   logic             legacy_mode;
   logic             cmd_wr, stat_wr, win_sel;
   logic             win_we;
   logic [IDX_W-1:0] win_widx;
   logic [31:0]      win_rdata, cmd_reg, stat_reg;

   if (LEGACY_EN) begin : g_mode_sel
      logic legacy_q;
      always_ff @(posedge clk) begin
         if (!rst_n) legacy_q <= mode_legacy;
      end
      assign legacy_mode = legacy_q;
   end else begin : g_mode_fixed
      assign legacy_mode = 1'b0;
   end

   assign win_sel = reg_addr[ADDR_W-1];
   assign cmd_wr  = reg_wr && (reg_addr == ADDR_W'(ADDR_CMD));
   assign stat_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));

   mbx_engine #(.DEPTH(WIN_DEPTH)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .legacy    (legacy_mode),
      .cmd_wr    (cmd_wr),
      .stat_wr   (stat_wr),
      .wdata     (reg_wdata),
      .be_valid  (be_valid),
      .be_done   (be_done),
      .be_err    (be_err),
      .be_ready  (be_ready),
      .win_we    (win_we),
      .win_idx   (win_widx),
      .cmd_valid (cmd_valid),
      .cmd_word  (cmd_reg),
      .stat_word (stat_reg)
   );

   mbx_window #(.DEPTH(WIN_DEPTH), .W(32)) u_window (
      .clk   (clk),
      .we    (win_we),
      .widx  (win_widx),
      .wdata (be_data),
      .ridx  (reg_addr[IDX_W-1:0]),
      .rdata (win_rdata)
   );

   always_comb begin
      if (win_sel)                                 reg_rdata = win_rdata;
      else if (reg_addr == ADDR_W'(ADDR_CMD))      reg_rdata = cmd_reg;
      else if (reg_addr == ADDR_W'(ADDR_STAT))     reg_rdata = stat_reg;
      else                                         reg_rdata = '0;
   end

   assign cmd_opcode = cmd_reg[15:0];
   assign cmd_qidx   = cmd_reg[31:16];
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
   parameter int WIN_DEPTH = 16,
   parameter int ADDR_W    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              cmd_valid,
   input logic              be_ready,
   input logic              be_done,
   input logic              legacy_mode,
   input logic [31:0]       cmd_reg,
   input logic [31:0]       stat_reg
);
   // R3
   stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      be_ready |-> !stat_reg[17]);

   // R3
   piece_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_reg[17] |-> (stat_reg[15:0] <= 16'(WIN_DEPTH)));

   // R11
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R2
   start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0 && reg_wdata != '0 && cmd_reg == '0)
      |=> (cmd_valid && cmd_reg == $past(reg_wdata)));

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0 && reg_wdata != '0 && cmd_reg != '0 &&
       stat_reg[27:18] == '0 && !be_done)
      |=> ($stable(cmd_reg) && !cmd_valid));

   // R9
   abort_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0 && reg_wdata == '0)
      |=> (cmd_reg == '0 && !stat_reg[16] && !stat_reg[17] && !be_ready));

   // R5
   last_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(1) && !reg_wdata[17] &&
       stat_reg[17] && !stat_reg[16] && !legacy_mode)
      |=> (cmd_reg == '0));

   // R10
   compat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_mode |-> (!be_ready && stat_reg == '0));
endmodule

bind cmd_mailbox mbx_chk #(.WIN_DEPTH(WIN_DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .cmd_valid   (cmd_valid),
   .be_ready    (be_ready),
   .be_done     (be_done),
   .legacy_mode (legacy_mode),
   .cmd_reg     (cmd_reg),
   .stat_reg    (stat_reg)
);

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
   localparam int DEPTH  = 16;
   localparam int ADDR_W = $clog2(DEPTH) + 1;
   localparam logic [ADDR_W-1:0] A_CMD  = 0;
   localparam logic [ADDR_W-1:0] A_STAT = 1;
   localparam int WIN0 = DEPTH;
   localparam int NV = 5;
   // {queue index, opcode, requested words}
   localparam logic [47:0] VEC [NV] = '{
      {16'd3,     16'd2, 16'd5},
      {16'd0,     16'd2, 16'd16},
      {16'd7,     16'd4, 16'd20},
      {16'd1,     16'd2, 16'd35},
      {16'hFFFF,  16'd5, 16'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_legacy = 1'b0;
   logic reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic cmd_valid;
   logic [15:0] cmd_opcode, cmd_qidx;
   logic be_valid = 1'b0;
   logic [31:0] be_data;
   logic be_ready;
   logic be_done = 1'b0;
   logic [9:0] be_err = '0;

   logic [31:0] src_base = '0;
   logic [31:0] src_cnt = '0;
   logic hs_prev = 1'b0;
   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cmd_mailbox #(.WIN_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_legacy(mode_legacy),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
      .cmd_qidx(cmd_qidx), .be_valid(be_valid), .be_data(be_data),
      .be_ready(be_ready), .be_done(be_done), .be_err(be_err)
   );

   // word source: k-th accepted word carries src_base + k
   assign be_data = src_base + src_cnt;
   always @(negedge clk) begin
      #2;
      if (!be_valid) begin
         src_cnt = '0;
         hs_prev = 1'b0;
      end else begin
         if (hs_prev) src_cnt = src_cnt + 1;
         hs_prev = be_valid && be_ready;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_rdy();
      logic [31:0] s;
      for (int i = 0; i < 200; i++) begin
         rd(A_STAT, s);
         if (s[17]) return;
         @(negedge clk);
      end
      chk("R3 ready timeout", 32'd0, 32'd1);
   endtask

   task automatic pulse_done(input logic [9:0] e);
      @(negedge clk);
      be_done = 1'b1; be_err = e;
      @(negedge clk);
      be_done = 1'b0; be_err = '0;
   endtask

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst_n = 1'b0; mode_legacy = m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      int rem, got, exp_sz;
      logic [15:0] req, opc, q;

      do_reset(1'b0);
      // R1 reset state
      rd(A_CMD, d);  chk("R1 reset cmd", d, 0);
      rd(A_STAT, d); chk("R1 reset stat", d, 0);
      chk("R1 reset cmd_valid", {31'd0, cmd_valid}, 0);
      chk("R1 reset be_ready", {31'd0, be_ready}, 0);

      // vector walk: chunked reads (R2 R3 R4 R5 R11)
      for (int v = 0; v < NV; v++) begin
         req = VEC[v][15:0]; opc = VEC[v][31:16]; q = VEC[v][47:32];
         src_base = 32'h1000 * (v + 1);
         wr(A_STAT, {16'd0, req});
         wr(A_CMD, {q, opc});
         chk("R2 cmd_valid", {31'd0, cmd_valid}, 1);
         chk("R2 opcode", {16'd0, cmd_opcode}, {16'd0, opc});
         chk("R2 qidx", {16'd0, cmd_qidx}, {16'd0, q});
         rd(A_STAT, d); chk("R2 busy set ready clear", {30'd0, d[17:16]}, 32'd1);
         be_valid = 1'b1;
         @(negedge clk);
         chk("R11 strobe one cycle", {31'd0, cmd_valid}, 0);
         rem = req; got = 0;
         while (rem > 0) begin
            exp_sz = (rem > DEPTH) ? DEPTH : rem;
            wait_rdy();
            rd(A_STAT, d);
            chk("R3 piece size", {16'd0, d[15:0]}, exp_sz);
            chk("R5 busy flag", {31'd0, d[16]}, (rem > exp_sz) ? 1 : 0);
            rd(ADDR_W'(WIN0), d);
            chk("R3 first word", d, src_base + got);
            rd(ADDR_W'(WIN0 + exp_sz - 1), d);
            chk("R3 last word", d, src_base + got + exp_sz - 1);
            chk("R3 stream held", {31'd0, be_ready}, 0);
            rd(A_CMD, d); chk("R5 cmd kept", d, {q, opc});
            wr(A_STAT, 32'd0);
            got += exp_sz; rem -= exp_sz;
         end
         be_valid = 1'b0;
         rd(A_CMD, d); chk("R5 cmd cleared", d, 0);
         repeat (2) @(negedge clk);
      end

      // R6 commandless acknowledge
      wr(A_STAT, 32'd0);
      wr(A_CMD, 32'd3);
      chk("R6 cmd_valid", {31'd0, cmd_valid}, 1);
      repeat (3) @(negedge clk);
      rd(A_STAT, d); chk("R6 waiting", d, 32'h0001_0000);
      pulse_done(10'd0);
      rd(A_STAT, d); chk("R6 ack shown", d, 32'h0002_0000);
      rd(A_CMD, d);  chk("R6 cmd kept", d, 3);
      wr(A_STAT, 32'd0);
      rd(A_CMD, d);  chk("R6 cmd cleared", d, 0);

      // R8 busy ignore, then R9 abort
      wr(A_STAT, 32'd20);
      wr(A_CMD, 32'd4);
      wr(A_CMD, 32'd7);
      chk("R8 no strobe", {31'd0, cmd_valid}, 0);
      rd(A_CMD, d); chk("R8 cmd unchanged", d, 4);
      be_valid = 1'b1;
      wr(A_CMD, 32'd0);
      rd(A_CMD, d);  chk("R9 cmd zero", d, 0);
      rd(A_STAT, d); chk("R9 flags clear", {30'd0, d[17:16]}, 0);
      chk("R9 stream off", {31'd0, be_ready}, 0);
      be_valid = 1'b0;
      repeat (2) @(negedge clk);

      // R4 ignored write, R12 held completion
      src_base = 32'h7000;
      wr(A_STAT, 32'd40);
      wr(A_CMD, 32'h0009_0002);
      be_valid = 1'b1;
      wait_rdy();
      be_valid = 1'b0;
      rd(A_STAT, d); chk("R3 full piece", d, 32'h0003_0010);
      wr(A_STAT, 32'h0002_0000);
      rd(A_STAT, d); chk("R4 bit17 set ignored", d, 32'h0003_0010);
      pulse_done(10'd0);
      wr(A_STAT, 32'd0);
      wait_rdy();
      rd(A_STAT, d); chk("R12 empty last piece", d, 32'h0002_0000);
      rd(A_CMD, d);  chk("R12 cmd kept", d, 32'h0009_0002);
      wr(A_STAT, 32'd0);
      rd(A_CMD, d);  chk("R12 cmd cleared", d, 0);

      // R7 error path and restart
      wr(A_STAT, 32'd30);
      wr(A_CMD, 32'd2);
      pulse_done(10'h155);
      rd(A_STAT, d); chk("R7 error piece", d, (32'h155 << 18) | 32'h0002_0000);
      wr(A_CMD, 32'd5);
      chk("R7 restart strobe", {31'd0, cmd_valid}, 1);
      rd(A_CMD, d);  chk("R7 restart cmd", d, 5);
      rd(A_STAT, d); chk("R7 error cleared", d, 32'h0001_0000);
      wr(A_CMD, 32'd0);

      // R10 compatibility mode
      do_reset(1'b1);
      wr(A_CMD, 32'h0005_0001);
      chk("R10 strobe", {31'd0, cmd_valid}, 1);
      chk("R10 opcode", {16'd0, cmd_opcode}, 1);
      chk("R10 qidx", {16'd0, cmd_qidx}, 5);
      wr(A_STAT, 32'h0002_0005);
      rd(A_STAT, d); chk("R10 status reads zero", d, 0);
      be_valid = 1'b1;
      @(negedge clk);
      chk("R10 stream off", {31'd0, be_ready}, 0);
      be_valid = 1'b0;
      rd(A_CMD, d); chk("R10 cmd held", d, 32'h0005_0001);
      pulse_done(10'd0);
      rd(A_CMD, d); chk("R10 cmd cleared", d, 0);

      summary();
      $finish;
   end
endmodule